// File: doc/BRIEF.md
# Core Clock Control Register and Settling Sequencer

This block is the digital side of a core clock generator. It holds one 32-bit control word that sets the loop multiplier, an optional divide-by-2 in front of the loop input, a post-divider and its enable, a loop bypass, a memory-clock ratio, and the choice of what drives a shared output pin. When reset is released, the multiplier field already holds a value decoded from two strap pins. All other fields come out of reset cleared.

Software writes the word through a plain write strobe and data bus and reads back the applied value. A write can touch any field that changes the loop frequency: the multiplier, the post-divider code, the input divider, the post-divider enable, or the bypass. Such a write is held in a pending copy while a settling counter runs, and the controls only change once the count ends. A write that touches none of those fields is applied at once. Writes that arrive while the counter runs replace the pending copy, and the last one is the one applied.

The block also keeps one sticky clock enable per peripheral. It drives the shared pin from either the local clock or the reset output. The analog loop is outside the block, and everything runs on the input clock.

Top module: `clkctl_top`

## Requirements
- R1: While `rst` is high, the applied word becomes the strap default and `busy` and every peripheral enable clear. The strap default is zero except bits 5:0, which take `cfg_pins` as follows: 00 gives 6, 01 gives 32, 10 gives 16, 11 gives 6. The default is readable on `rd_data` and the control outputs on the first low-reset cycle.
- R2: The word layout is as follows: multiplier in bits 5:0, post-divider code in bits 7:6, input divide-by-2 in bit 8, post-divider enable in bit 9, pin clock select in bit 12, bypass in bit 15, memory ratio code in bits 20:18. `rd_data` returns the whole applied word one cycle after it is applied.
- R3: A write made while idle is applied on its own edge if it leaves bits 5:0, 7:6, 8, 9 and 15 equal to the applied word. Its value is then visible on `rd_data` and the outputs one cycle later.
- R4: A write made while idle that changes any of bits 5:0, 7:6, 8, 9 or 15 raises `busy` on its own edge, and `busy` stays high for exactly SETTLE_CYCLES (4096) cycles. The outputs and `rd_data` keep their old values throughout. The new value appears one cycle after `busy` falls.
- R5: Writes made while `busy` is high replace the pending word without restarting the count. The last one is applied when the count ends.
- R6: `pll_mult` equals bits 5:0, `in_div2` equals bit 8 and `pll_bypass` equals bit 15. `post_div_shift` equals bits 7:6 when bit 9 is set, and 0 otherwise.
- R7: `mem_ratio_x2` gives twice the memory clock ratio. Code 0 gives 4, code 1 gives 5, code 2 gives 6, code 3 gives 7, and codes 4 to 7 give 8.
- R8: `shared_pin` follows `reset_out_src` while applied bit 12 is clear, and follows `loc_clk` while it is set.
- R9: A high `periph_on[i]` sets `periph_clk_en[i]` on that edge. The bit then stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock, clocks all state |
| rst | input | 1 | Synchronous active-high reset |
| cfg_pins | input | 2 | Strap pins decoded during reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Applied control word |
| busy | output | 1 | Settling counter running |
| periph_on | input | 4 | Peripheral enable events |
| periph_clk_en | output | 4 | Sticky peripheral clock enables |
| pll_mult | output | 6 | Loop multiplier |
| post_div_shift | output | 2 | Effective post-divide as a power of two |
| in_div2 | output | 1 | Divide-by-2 before the loop input |
| pll_bypass | output | 1 | Core clock taken from the loop input |
| mem_ratio_x2 | output | 4 | Memory clock ratio times two |
| loc_clk | input | 1 | Local clock for the shared pin |
| reset_out_src | input | 1 | Reset output for the shared pin |
| shared_pin | output | 1 | Shared pin drive |

## Verification
Let edge E be the write edge. An idle write that needs no settling is due on `rd_data` and the control outputs at edge E+1. A settling write makes `busy` read high just after E, still high just after E+4095 and low just after E+4096, and its value is due at E+4097. The bench records the edge number at which each write is sampled. It queues the expected word with its due edge and compares it in the half cycle after that edge. It reads `busy` and the unchanged old word at the E+4095 and E+4096 boundaries. Peripheral enables are due one edge after the event, and the shared pin follows its sources with no delay once bit 12 is applied.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  localparam int REG_W      = 32;
  localparam int MULT_W     = 6;
  localparam int MULT_LSB   = 0;
  localparam int PDIV_W     = 2;
  localparam int PDIV_LSB   = 6;
  localparam int IDIV_BIT   = 8;
  localparam int PDEN_BIT   = 9;
  localparam int PINSEL_BIT = 12;
  localparam int BYP_BIT    = 15;
  localparam int MRAT_W     = 3;
  localparam int MRAT_LSB   = 18;
  localparam int RATIO_W    = 4;

  // Fields whose change must wait for the loop to settle
  localparam logic [REG_W-1:0] SETTLE_MASK =
    (REG_W'((1 << MULT_W) - 1) << MULT_LSB) |
    (REG_W'((1 << PDIV_W) - 1) << PDIV_LSB) |
    (REG_W'(1) << IDIV_BIT) |
    (REG_W'(1) << PDEN_BIT) |
    (REG_W'(1) << BYP_BIT);

  typedef struct packed {
    logic [MULT_W-1:0]  mult;
    logic [PDIV_W-1:0]  post_shift;
    logic               in_div2;
    logic               bypass;
    logic               pin_clk_sel;
    logic [RATIO_W-1:0] mem_x2;
  } clk_ctrl_t;

  function automatic logic [MULT_W-1:0] strap_mult(input logic [1:0] pins);
    case (pins)
      2'b01:   strap_mult = MULT_W'(32);
      2'b10:   strap_mult = MULT_W'(16);
      default: strap_mult = MULT_W'(6);
    endcase
  endfunction

  function automatic logic [REG_W-1:0] strap_word(input logic [1:0] pins);
    strap_word = REG_W'(strap_mult(pins)) << MULT_LSB;
  endfunction

  function automatic clk_ctrl_t decode_ctrl(input logic [REG_W-1:0] w);
    clk_ctrl_t        c;
    logic [MRAT_W-1:0] code;
    code          = w[MRAT_LSB +: MRAT_W];
    c.mult        = w[MULT_LSB +: MULT_W];
    c.post_shift  = w[PDEN_BIT] ? w[PDIV_LSB +: PDIV_W] : '0;
    c.in_div2     = w[IDIV_BIT];
    c.bypass      = w[BYP_BIT];
    c.pin_clk_sel = w[PINSEL_BIT];
    if (code > MRAT_W'(4)) c.mem_x2 = RATIO_W'(8);
    else                   c.mem_x2 = RATIO_W'(4) + RATIO_W'(code);
    decode_ctrl = c;
  endfunction
endpackage

// File: rtl/clkctl_settle.sv
module clkctl_settle #(
  parameter int SETTLE_CYCLES = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CNT_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        cnt  <= CNT_W'(SETTLE_CYCLES - 1);
      end
    end else if (cnt == '0) begin
      busy <= 1'b0;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done = busy && (cnt == '0);

  // R4
  settle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt != '0) |=> busy);

  // R4
  settle_count_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$past(done)) |-> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/clkctl_regs.sv
module clkctl_regs
  import clkctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       cfg_pins,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             busy,
  input  logic             done,
  output logic             start,
  output logic [REG_W-1:0] applied,
  output logic [REG_W-1:0] boot_val
);
  logic [REG_W-1:0] pending;
  logic             needs_settle;

  assign boot_val     = strap_word(cfg_pins);
  assign needs_settle = ((wr_data ^ applied) & SETTLE_MASK) != '0;
  assign start        = wr_en && !busy && needs_settle;

  always_ff @(posedge clk) begin
    if (rst) begin
      applied <= boot_val;
      pending <= boot_val;
    end else if (busy) begin
      if (wr_en) pending <= wr_data;
      if (done)  applied <= wr_en ? wr_data : pending;
    end else if (wr_en) begin
      if (needs_settle) pending <= wr_data;
      else              applied <= wr_data;
    end
  end

  // R4
  applied_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> $stable(applied));

  // R3
  quiet_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !busy && !needs_settle) |=> (applied == $past(wr_data)));
endmodule

// File: rtl/clkctl_decode.sv
module clkctl_decode
  import clkctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] applied,
  input  logic [REG_W-1:0] boot_val,
  output clk_ctrl_t        ctrl,
  output logic [REG_W-1:0] rd_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= decode_ctrl(boot_val);
      rd_q <= boot_val;
    end else begin
      ctrl <= decode_ctrl(applied);
      rd_q <= applied;
    end
  end

  // R7
  mem_ratio_range_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl.mem_x2 >= RATIO_W'(4)) && (ctrl.mem_x2 <= RATIO_W'(8)));

  // R6
  post_div_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_q[PDEN_BIT] |-> (ctrl.post_shift == '0));
endmodule

// File: rtl/clkctl_gate.sv
module clkctl_gate #(
  parameter int N_PERIPH = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_PERIPH-1:0] on_evt,
  output logic [N_PERIPH-1:0] en
);
  for (genvar i = 0; i < N_PERIPH; i++) begin : g_en
    always_ff @(posedge clk) begin
      if (rst)            en[i] <= 1'b0;
      else if (on_evt[i]) en[i] <= 1'b1;
    end

    // R9
    sticky_en_chk: assert property (@(posedge clk) disable iff (rst)
      en[i] |=> en[i]);
  end
endmodule

// File: rtl/clkctl_top.sv
module clkctl_top
  import clkctl_pkg::*;
#(
  parameter int SETTLE_CYCLES = 4096,
  parameter int N_PERIPH      = 4
) (
  input  logic                clk_in,
  input  logic                rst,
  input  logic [1:0]          cfg_pins,
  input  logic                wr_en,
  input  logic [REG_W-1:0]    wr_data,
  output logic [REG_W-1:0]    rd_data,
  output logic                busy,
  input  logic [N_PERIPH-1:0] periph_on,
  output logic [N_PERIPH-1:0] periph_clk_en,
  output logic [MULT_W-1:0]   pll_mult,
  output logic [PDIV_W-1:0]   post_div_shift,
  output logic                in_div2,
  output logic                pll_bypass,
  output logic [RATIO_W-1:0]  mem_ratio_x2,
  input  logic                loc_clk,
  input  logic                reset_out_src,
  output logic                shared_pin
);
  logic             start;
  logic             done;
  logic [REG_W-1:0] applied;
  logic [REG_W-1:0] boot_val;
  clk_ctrl_t        ctrl;

  clkctl_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk(clk_in), .rst(rst), .start(start), .busy(busy), .done(done)
  );

  clkctl_regs u_regs (
    .clk(clk_in), .rst(rst), .cfg_pins(cfg_pins), .wr_en(wr_en),
    .wr_data(wr_data), .busy(busy), .done(done), .start(start),
    .applied(applied), .boot_val(boot_val)
  );

  clkctl_decode u_decode (
    .clk(clk_in), .rst(rst), .applied(applied), .boot_val(boot_val),
    .ctrl(ctrl), .rd_q(rd_data)
  );

  clkctl_gate #(.N_PERIPH(N_PERIPH)) u_gate (
    .clk(clk_in), .rst(rst), .on_evt(periph_on), .en(periph_clk_en)
  );

  assign pll_mult       = ctrl.mult;
  assign post_div_shift = ctrl.post_shift;
  assign in_div2        = ctrl.in_div2;
  assign pll_bypass     = ctrl.bypass;
  assign mem_ratio_x2   = ctrl.mem_x2;
  assign shared_pin     = ctrl.pin_clk_sel ? loc_clk : reset_out_src;
endmodule

// File: tb/clkctl_top_bench.sv
module clkctl_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 4096;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cfg_pins = 2'b00;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        busy;
  logic [3:0]  periph_on = '0;
  logic [3:0]  periph_clk_en;
  logic [5:0]  pll_mult;
  logic [1:0]  post_div_shift;
  logic        in_div2, pll_bypass;
  logic [3:0]  mem_ratio_x2;
  logic        loc_clk = 1'b0;
  logic        reset_out_src = 1'b0;
  logic        shared_pin;

  int     checks = 0;
  int     errors = 0;
  longint cyc = 0;

  typedef struct {
    longint      due;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sbq[$];

  clkctl_top u_clkctl_top (
    .clk_in(clk), .rst(rst), .cfg_pins(cfg_pins), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .busy(busy),
    .periph_on(periph_on), .periph_clk_en(periph_clk_en),
    .pll_mult(pll_mult), .post_div_shift(post_div_shift),
    .in_div2(in_div2), .pll_bypass(pll_bypass),
    .mem_ratio_x2(mem_ratio_x2), .loc_clk(loc_clk),
    .reset_out_src(reset_out_src), .shared_pin(shared_pin)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] boot_of(input logic [1:0] p);
    case (p)
      2'b01:   return 32'd32;
      2'b10:   return 32'd16;
      default: return 32'd6;
    endcase
  endfunction

  // Expected {mult, shift, div2, bypass, ratio_x2} from R6 and R7
  function automatic logic [13:0] outs_of(input logic [31:0] w);
    logic [1:0] sh;
    logic [3:0] rx;
    sh = w[9] ? w[7:6] : 2'd0;
    rx = (w[20:18] > 3'd4) ? 4'd8 : 4'd4 + {1'b0, w[20:18]};
    return {w[5:0], sh, w[8], w[15], rx};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic chk_word(input logic [31:0] exp, input string tag);
    chk(tag, 64'(rd_data), 64'(exp));
    chk(tag, 64'({pll_mult, post_div_shift, in_div2, pll_bypass, mem_ratio_x2}),
        64'(outs_of(exp)));
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    item_t it;
    if (sbq.size() > 0 && sbq[0].due <= cyc) begin
      it = sbq.pop_front();
      if (it.due != cyc) chk({it.tag, " late"}, 64'(cyc), 64'(it.due));
      chk_word(it.exp, it.tag);
    end
  end

  task automatic wait_until(input longint t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic do_write(input logic [31:0] d, output longint e);
    wr_en   = 1'b1;
    wr_data = d;
    e       = cyc + 1;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic push(input longint due, input logic [31:0] exp, input string tag);
    item_t it;
    it.due = due; it.exp = exp; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic do_reset(input logic [1:0] p);
    rst = 1'b1;
    cfg_pins = p;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk_word(boot_of(p), "R1 strap default");
    chk("R1 busy after reset", 64'(busy), 64'd0);
    chk("R9 enables after reset", 64'(periph_clk_en), 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    longint      e, e0;
    logic [31:0] cur, nxt, b_word, c_word;

    @(negedge clk);
    do_reset(2'b00);
    do_reset(2'b11);
    do_reset(2'b10);
    do_reset(2'b01);
    cur = 32'd32;

    // R8: pin follows reset source while bit 12 is clear
    reset_out_src = 1'b1; loc_clk = 1'b0; #1;
    chk("R8 pin reset source", 64'(shared_pin), 64'd1);

    // R3 / R2: write with no settling fields changed
    nxt = cur | (32'd1 << 12) | (32'd2 << 18);
    do_write(nxt, e);
    push(e + 1, nxt, "R3 immediate write");
    chk("R3 no busy", 64'(busy), 64'd0);
    cur = nxt;
    wait_until(e + 1);
    reset_out_src = 1'b0; loc_clk = 1'b1; #1;
    chk("R8 pin local clock high", 64'(shared_pin), 64'd1);
    loc_clk = 1'b0; #1;
    chk("R8 pin local clock low", 64'(shared_pin), 64'd0);

    // R7: every memory ratio code
    for (int c = 0; c < 8; c++) begin
      nxt = cur;
      nxt[20:18] = c[2:0];
      do_write(nxt, e);
      push(e + 1, nxt, "R7 ratio code");
      cur = nxt;
      wait_until(e + 1);
    end

    // R4 / R6: settling write, enable clear so shift must be 0
    nxt = (cur & ~32'h0000_83FF) | 32'd16 | (32'd3 << 6) | (32'd1 << 8) | (32'd1 << 15);
    do_write(nxt, e);
    push(e + SETTLE + 1, nxt, "R4 settled word R6 fields");
    chk("R4 busy rises", 64'(busy), 64'd1);
    chk("R4 old word kept", 64'(rd_data), 64'(cur));
    wait_until(e + SETTLE - 1);
    chk("R4 busy at last count", 64'(busy), 64'd1);
    chk("R4 old word before end", 64'(rd_data), 64'(cur));
    wait_until(e + SETTLE);
    chk("R4 busy falls", 64'(busy), 64'd0);
    chk("R4 old word at fall", 64'(rd_data), 64'(cur));
    cur = nxt;
    wait_until(e + SETTLE + 1);

    // R5: queued writes, latest wins, no restart
    nxt    = (cur & ~32'h3F) | 32'd6;
    b_word = (cur & ~32'h3F) | 32'd32;
    c_word = (cur & ~32'h0000_83FF) | 32'd16 | (32'd1 << 9) | (32'd2 << 6) | (32'd1 << 8);
    do_write(nxt, e0);
    push(e0 + SETTLE + 1, c_word, "R5 latest write applied");
    wait_until(e0 + 100);
    do_write(b_word, e);
    wait_until(e0 + 200);
    do_write(c_word, e);
    chk("R5 still busy", 64'(busy), 64'd1);
    wait_until(e0 + SETTLE);
    chk("R5 count not restarted", 64'(busy), 64'd0);
    chk("R5 old word at fall", 64'(rd_data), 64'(cur));
    wait_until(e0 + SETTLE + 1);

    // R9: sticky peripheral enables
    periph_on = 4'b0100;
    @(negedge clk);
    periph_on = 4'b0000;
    chk("R9 first enable", 64'(periph_clk_en), 64'h4);
    periph_on = 4'b0001;
    @(negedge clk);
    periph_on = 4'b0000;
    chk("R9 second enable", 64'(periph_clk_en), 64'h5);
    repeat (5) @(negedge clk);
    chk("R9 enables stay set", 64'(periph_clk_en), 64'h5);

    do_reset(2'b10);
    wait_until(cyc + 2);
    chk("R1 queue drained", 64'(sbq.size()), 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule